// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations that system software loads and maintains directly. A lookup presents a 32-bit virtual address, the current address-space identifier and an access kind. One clock later the block returns one of three outcomes: a translated physical address, a miss, or a protection fault. A miss means the translation is not present, and the caller is expected to trap to software rather than walk any table.

Each slot holds a virtual page number, a physical frame number, an 8-bit address-space tag, a global flag, three permission bits, a dirty flag and a valid flag. A privileged management port lets software search for a translation, read a slot, overwrite a chosen slot, overwrite a slot picked at random, invalidate every slot at once, and set how many low-numbered slots are pinned. Pinned slots are never chosen by the random overwrite, so critical mappings stay resident.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, the pinned count is zero and no result is flagged; a lookup made right after reset reports a miss.
- R2: The page number is address bits 30..12 and the offset is bits 11..0. A hit returns the stored frame number in bits 35..12 and the untouched offset below it, on `rs_*` one clock after `lk_valid`. An address with bit 31 set never matches.
- R3: A slot matches only when it is valid, its page number equals the lookup page, and either its global flag is set or its tag equals `lk_asid`.
- R4: Whenever `rs_valid` is high exactly one of `rs_hit`, `rs_miss` or `rs_fault` is high; when it is low, none of them is. `rs_pa` is zero unless `rs_hit` is high.
- R5: Permission bit 0 is read, bit 1 is write and bit 2 is execute. `lk_acc` is one-hot with bit 0 read, bit 1 write and bit 2 fetch. A matching access whose bit is not granted, or a write to a slot whose dirty flag is clear, reports a fault and no address.
- R6: A flush clears the valid flag of every slot in one operation.
- R7: A random write lands only on a slot whose index is at least the pinned count and below the slot count. A pinned count at or above the slot count is stored as the slot count minus one.
- R8: A probe searches with `mg_vpn` and `mg_asid` using the matching rule of R3. It returns the lowest matching index on `mg_slot` with `mg_nf` low, or `mg_nf` high when nothing matches.
- R9: An indexed read returns every field of slot `mg_index` on the `rd_*` outputs, and an indexed write replaces every field of that slot. A management write takes effect at the clock edge, so a lookup issued in the same cycle sees the old contents.
- R10: When several slots match, the lowest index supplies the result, and `rs_multi` (for lookups) or `mg_multi` (for probes) is raised.
- R11: Slots with the same page number and different tags translate independently to their own frames, and different pages may share one frame.
- R12: Operation codes on `mg_op` are 0 idle, 1 probe, 2 read, 3 indexed write, 4 random write, 5 flush and 6 set pinned count (from `mg_wired`). Every non-idle code raises `mg_ack` for one cycle on the following clock, and `mg_slot` names the slot written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space tag of the running context |
| lk_acc | input | 3 | One-hot access kind: read, write, fetch |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Translation granted |
| rs_miss | output | 1 | No matching slot |
| rs_fault | output | 1 | Matching slot denies the access |
| rs_multi | output | 1 | More than one slot matched the lookup |
| rs_pa | output | 36 | Physical address, zero unless hit |
| mg_op | input | 3 | Management operation code |
| mg_index | input | 5 | Slot for indexed read or write |
| mg_wired | input | 6 | New pinned slot count |
| mg_vpn | input | 19 | Page number for probe or write |
| mg_pfn | input | 24 | Frame number to write |
| mg_asid | input | 8 | Tag for probe or write |
| mg_global | input | 1 | Global flag to write |
| mg_prot | input | 3 | Permission bits to write |
| mg_dirty | input | 1 | Dirty flag to write |
| mg_valid | input | 1 | Valid flag to write |
| mg_ack | output | 1 | Management operation completed |
| mg_nf | output | 1 | Probe found no match |
| mg_multi | output | 1 | Probe found more than one match |
| mg_slot | output | 5 | Probed or written slot index |
| rd_vpn | output | 19 | Read-back page number |
| rd_pfn | output | 24 | Read-back frame number |
| rd_asid | output | 8 | Read-back tag |
| rd_global | output | 1 | Read-back global flag |
| rd_prot | output | 3 | Read-back permission bits |
| rd_dirty | output | 1 | Read-back dirty flag |
| rd_valid | output | 1 | Read-back valid flag |

## Verification
On every cycle the assertions hold the result encoding to exactly one status with a zero address outside a hit, require a hit to carry the requested page offset, require a multi-match flag to come only with a matching result, require a flush to leave no valid slot, and require a random write to land at or above the pinned count. Which frame a given tag and page produce, the global override, the dirty-bit write fault, probe indices, read-back fields, the ordering of a same-cycle write and lookup, and the clamping of an oversized pinned count depend on the contents loaded, so only the bench's scenarios with their computed expectations show them.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROBE = 3'd1,
        OP_READ  = 3'd2,
        OP_WIDX  = 3'd3,
        OP_WRND  = 3'd4,
        OP_FLUSH = 3'd5,
        OP_WIRED = 3'd6
    } mg_op_e;

    // Bit positions shared by the access-kind input and the permission field
    localparam int ACC_RD = 0;
    localparam int ACC_WR = 1;
    localparam int ACC_EX = 2;
    localparam int PERM_W = 3;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/xlat_match.sv
// Parallel tag compare across every slot with lowest-index priority.
module xlat_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    input  logic [ENTRIES-1:0]             ent_glb,
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic                           q_en,
    input  logic [VPN_W-1:0]               q_vpn,
    input  logic [ASID_W-1:0]              q_asid,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx,
    output logic                           multi
);

    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = q_en && ent_valid[i] && (ent_vpn[i] == q_vpn) &&
                          (ent_glb[i] || (ent_asid[i] == q_asid));
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit   = |match;
    assign multi = |(match & (match - ENTRIES'(1)));

endmodule

// File: rtl/xlat_victim.sv
// Free-running LFSR folded into the replaceable slot range [wired, ENTRIES-1].
module xlat_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   wired,
    output logic [IDX_W-1:0] victim
);
    import xlat_pkg::*;

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;
    logic [IDX_W:0]    span;

    always_comb begin
        lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        span   = (IDX_W+1)'(ENTRIES) - wired;
        victim = IDX_W'(wired + (IDX_W+1)'(lfsr_q % LFSR_W'(span)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= lfsr_d;
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int ENTRIES  = 32,
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 12,
    parameter int VPN_W    = 19,
    parameter int PFN_W    = 24,
    parameter int ASID_W   = 8,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int PA_W    = PFN_W + PG_SHIFT,
    localparam int PERM_W  = xlat_pkg::PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PERM_W-1:0] lk_acc,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic              rs_fault,
    output logic              rs_multi,
    output logic [PA_W-1:0]   rs_pa,
    input  logic [2:0]        mg_op,
    input  logic [IDX_W-1:0]  mg_index,
    input  logic [IDX_W:0]    mg_wired,
    input  logic [VPN_W-1:0]  mg_vpn,
    input  logic [PFN_W-1:0]  mg_pfn,
    input  logic [ASID_W-1:0] mg_asid,
    input  logic              mg_global,
    input  logic [PERM_W-1:0] mg_prot,
    input  logic              mg_dirty,
    input  logic              mg_valid,
    output logic              mg_ack,
    output logic              mg_nf,
    output logic              mg_multi,
    output logic [IDX_W-1:0]  mg_slot,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic [ASID_W-1:0] rd_asid,
    output logic              rd_global,
    output logic [PERM_W-1:0] rd_prot,
    output logic              rd_dirty,
    output logic              rd_valid
);
    import xlat_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0]             glb;
        logic [ENTRIES-1:0][PERM_W-1:0] prot;
        logic [ENTRIES-1:0]             dirty;
        logic [ENTRIES-1:0]             valid;
        logic [IDX_W:0]                 wired;
        logic                           rs_valid;
        logic                           rs_hit;
        logic                           rs_miss;
        logic                           rs_fault;
        logic                           rs_multi;
        logic [PA_W-1:0]                rs_pa;
        logic                           mg_ack;
        logic                           mg_nf;
        logic                           mg_multi;
        logic [IDX_W-1:0]               mg_slot;
        logic [VPN_W-1:0]               rd_vpn;
        logic [PFN_W-1:0]               rd_pfn;
        logic [ASID_W-1:0]              rd_asid;
        logic                           rd_global;
        logic [PERM_W-1:0]              rd_prot;
        logic                           rd_dirty;
        logic                           rd_valid;
    } state_t;

    state_t q, d;

    // Lookup-side decode
    logic             lk_user;
    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit, lk_multi;
    logic [IDX_W-1:0] lk_idx;

    assign lk_user = ~|lk_va[VA_W-1:PG_SHIFT+VPN_W];
    assign lk_vpn  = lk_va[PG_SHIFT +: VPN_W];

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .ent_vpn  (q.vpn),
        .ent_asid (q.asid),
        .ent_glb  (q.glb),
        .ent_valid(q.valid),
        .q_en     (lk_valid & lk_user),
        .q_vpn    (lk_vpn),
        .q_asid   (lk_asid),
        .hit      (lk_hit),
        .idx      (lk_idx),
        .multi    (lk_multi)
    );

    // Probe-side search
    logic             pr_hit, pr_multi;
    logic [IDX_W-1:0] pr_idx;

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr_match (
        .ent_vpn  (q.vpn),
        .ent_asid (q.asid),
        .ent_glb  (q.glb),
        .ent_valid(q.valid),
        .q_en     (mg_op == OP_PROBE),
        .q_vpn    (mg_vpn),
        .q_asid   (mg_asid),
        .hit      (pr_hit),
        .idx      (pr_idx),
        .multi    (pr_multi)
    );

    // Replacement index for random writes
    logic [IDX_W-1:0] vic_idx;

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .wired (q.wired),
        .victim(vic_idx)
    );

    logic             lk_ok;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        d = q;

        // Lookup result
        lk_ok = (|(lk_acc & q.prot[lk_idx])) &&
                !(lk_acc[ACC_WR] && !q.dirty[lk_idx]);
        d.rs_valid = lk_valid;
        d.rs_hit   = 1'b0;
        d.rs_miss  = 1'b0;
        d.rs_fault = 1'b0;
        d.rs_multi = 1'b0;
        d.rs_pa    = '0;
        if (lk_valid) begin
            d.rs_multi = lk_multi;
            if (!lk_hit) begin
                d.rs_miss = 1'b1;
            end else if (lk_ok) begin
                d.rs_hit = 1'b1;
                d.rs_pa  = {q.pfn[lk_idx], lk_va[PG_SHIFT-1:0]};
            end else begin
                d.rs_fault = 1'b1;
            end
        end

        // Management operation
        d.mg_ack = (mg_op != OP_IDLE);
        wr_en    = 1'b0;
        wr_idx   = mg_index;
        case (mg_op_e'(mg_op))
            OP_PROBE: begin
                d.mg_nf    = !pr_hit;
                d.mg_multi = pr_multi;
                d.mg_slot  = pr_idx;
            end
            OP_READ: begin
                d.mg_slot   = mg_index;
                d.rd_vpn    = q.vpn[mg_index];
                d.rd_pfn    = q.pfn[mg_index];
                d.rd_asid   = q.asid[mg_index];
                d.rd_global = q.glb[mg_index];
                d.rd_prot   = q.prot[mg_index];
                d.rd_dirty  = q.dirty[mg_index];
                d.rd_valid  = q.valid[mg_index];
            end
            OP_WIDX: begin
                wr_en = 1'b1;
            end
            OP_WRND: begin
                wr_en  = 1'b1;
                wr_idx = vic_idx;
            end
            OP_FLUSH: begin
                d.valid = '0;
            end
            OP_WIRED: begin
                if (mg_wired >= (IDX_W+1)'(ENTRIES))
                    d.wired = (IDX_W+1)'(ENTRIES - 1);
                else
                    d.wired = mg_wired;
            end
            default: ;
        endcase

        if (wr_en) begin
            d.mg_slot          = wr_idx;
            d.vpn[wr_idx]      = mg_vpn;
            d.pfn[wr_idx]      = mg_pfn;
            d.asid[wr_idx]     = mg_asid;
            d.glb[wr_idx]      = mg_global;
            d.prot[wr_idx]     = mg_prot;
            d.dirty[wr_idx]    = mg_dirty;
            d.valid[wr_idx]    = mg_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Views used by the bound checker
    logic [IDX_W:0]     wired_q;
    logic [ENTRIES-1:0] valid_q;
    assign wired_q = q.wired;
    assign valid_q = q.valid;

    assign rs_valid  = q.rs_valid;
    assign rs_hit    = q.rs_hit;
    assign rs_miss   = q.rs_miss;
    assign rs_fault  = q.rs_fault;
    assign rs_multi  = q.rs_multi;
    assign rs_pa     = q.rs_pa;
    assign mg_ack    = q.mg_ack;
    assign mg_nf     = q.mg_nf;
    assign mg_multi  = q.mg_multi;
    assign mg_slot   = q.mg_slot;
    assign rd_vpn    = q.rd_vpn;
    assign rd_pfn    = q.rd_pfn;
    assign rd_asid   = q.rd_asid;
    assign rd_global = q.rd_global;
    assign rd_prot   = q.rd_prot;
    assign rd_dirty  = q.rd_dirty;
    assign rd_valid  = q.rd_valid;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int ENTRIES  = 32,
    parameter int PG_SHIFT = 12,
    parameter int PA_W     = 36,
    parameter int IDX_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PG_SHIFT-1:0] lk_off,
    input logic                rs_valid,
    input logic                rs_hit,
    input logic                rs_miss,
    input logic                rs_fault,
    input logic                rs_multi,
    input logic [PA_W-1:0]     rs_pa,
    input logic [2:0]          mg_op,
    input logic                mg_ack,
    input logic [IDX_W-1:0]    mg_slot,
    input logic [IDX_W:0]      wired_q,
    input logic [ENTRIES-1:0]  valid_q
);
    import xlat_pkg::*;

    a_r4_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> $countones({rs_hit, rs_miss, rs_fault}) == 1);

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> !(rs_hit || rs_miss || rs_fault));

    a_r4_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> rs_pa == '0);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_pa[PG_SHIFT-1:0] == $past(lk_off));

    a_r10_multi_matched: assert property (@(posedge clk) disable iff (!rst_n)
        rs_multi |-> (rs_hit || rs_fault));

    a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_ack && $past(mg_op) == 3'(OP_FLUSH)) |-> valid_q == '0);

    a_r7_above_wired: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_ack && $past(mg_op) == 3'(OP_WRND)) |-> ({1'b0, mg_slot} >= $past(wired_q)));

endmodule

bind xlat_cache xlat_cache_chk #(
    .ENTRIES (ENTRIES),
    .PG_SHIFT(PG_SHIFT),
    .PA_W    (PA_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_off  (lk_va[PG_SHIFT-1:0]),
    .rs_valid(rs_valid),
    .rs_hit  (rs_hit),
    .rs_miss (rs_miss),
    .rs_fault(rs_fault),
    .rs_multi(rs_multi),
    .rs_pa   (rs_pa),
    .mg_op   (mg_op),
    .mg_ack  (mg_ack),
    .mg_slot (mg_slot),
    .wired_q (wired_q),
    .valid_q (valid_q)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
    import xlat_pkg::*;

    localparam int N = 32;
    localparam int IW = $clog2(N);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic [2:0]  lk_acc = '0;
    logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_multi;
    logic [35:0] rs_pa;
    logic [2:0]  mg_op = '0;
    logic [IW-1:0] mg_index = '0;
    logic [IW:0] mg_wired = '0;
    logic [18:0] mg_vpn = '0;
    logic [23:0] mg_pfn = '0;
    logic [7:0]  mg_asid = '0;
    logic        mg_global = 1'b0;
    logic [2:0]  mg_prot = '0;
    logic        mg_dirty = 1'b0;
    logic        mg_valid = 1'b0;
    logic        mg_ack, mg_nf, mg_multi;
    logic [IW-1:0] mg_slot;
    logic [18:0] rd_vpn;
    logic [23:0] rd_pfn;
    logic [7:0]  rd_asid;
    logic        rd_global, rd_dirty, rd_valid;
    logic [2:0]  rd_prot;

    always #5 clk = ~clk;

    xlat_cache #(.ENTRIES(N)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_RD = 3'b001, A_WR = 3'b010, A_EX = 3'b100;
    localparam logic [1:0] ST_HIT = 2'd0, ST_MISS = 2'd1, ST_FLT = 2'd2;

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic [2:0]  acc;
        logic [1:0]  st;
        logic [35:0] pa;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000A123, 8'd1,  A_RD, ST_HIT,  36'h000064123},
        '{32'h0000A123, 8'd2,  A_RD, ST_HIT,  36'h0000AA123},
        '{32'h0000A123, 8'd3,  A_RD, ST_MISS, 36'h0},
        '{32'h00032FFF, 8'd2,  A_EX, ST_HIT,  36'h000065FFF},
        '{32'h00032000, 8'd2,  A_WR, ST_FLT,  36'h0},
        '{32'h00010ABC, 8'd1,  A_RD, ST_HIT,  36'h000065ABC},
        '{32'h00020004, 8'd77, A_RD, ST_HIT,  36'hABCDEF004},
        '{32'h00020004, 8'd0,  A_WR, ST_FLT,  36'h0},
        '{32'h00020004, 8'd0,  A_EX, ST_FLT,  36'h0},
        '{32'h00021800, 8'd1,  A_WR, ST_HIT,  36'h123456800},
        '{32'h00021800, 8'd2,  A_RD, ST_MISS, 36'h0},
        '{32'h00099000, 8'd1,  A_RD, ST_MISS, 36'h0},
        '{32'h00010000, 8'd2,  A_RD, ST_MISS, 36'h0},
        '{32'h8000A123, 8'd1,  A_RD, ST_MISS, 36'h0}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [2:0] acc);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_acc = acc;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic set_fields(input logic [18:0] vpn, input logic [23:0] pfn, input logic [7:0] asid,
                              input bit g, input logic [2:0] prot, input bit dirty);
        mg_vpn = vpn; mg_pfn = pfn; mg_asid = asid; mg_global = g;
        mg_prot = prot; mg_dirty = dirty; mg_valid = 1'b1;
    endtask

    task automatic mgmt(input mg_op_e op);
        @(negedge clk);
        mg_op = op;
        @(negedge clk);
        mg_op = OP_IDLE;
    endtask

    task automatic wr_idx(input int idx, input logic [18:0] vpn, input logic [23:0] pfn,
                          input logic [7:0] asid, input bit g, input logic [2:0] prot, input bit dirty);
        set_fields(vpn, pfn, asid, g, prot, dirty);
        mg_index = IW'(idx);
        mgmt(OP_WIDX);
    endtask

    task automatic probe(input logic [18:0] vpn, input logic [7:0] asid);
        mg_vpn = vpn; mg_asid = asid;
        mgmt(OP_PROBE);
    endtask

    function automatic logic [2:0] st_bits(input logic [1:0] st);
        case (st)
            ST_HIT:  return 3'b100;
            ST_MISS: return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired before the run completed");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!rs_valid && !rs_hit && !mg_ack, "R1 reset outputs idle",
              {61'd0, rs_valid, rs_hit, mg_ack}, 64'd0);
        lookup(32'h0000A123, 8'd1, A_RD);
        check(rs_valid && rs_miss && !rs_hit, "R1 lookup after reset misses",
              {61'd0, rs_hit, rs_miss, rs_fault}, 64'b010);

        // R12: load table, check ack and written slot
        wr_idx(2, 19'h0000A, 24'h000064, 8'd1, 1'b0, 3'b111, 1'b1);
        check(mg_ack && mg_slot == 5'd2, "R12 indexed write ack/slot", {59'd0, mg_slot}, 64'd2);
        wr_idx(3, 19'h0000A, 24'h0000AA, 8'd2, 1'b0, 3'b111, 1'b1);
        wr_idx(4, 19'h00032, 24'h000065, 8'd2, 1'b0, 3'b101, 1'b0);
        wr_idx(5, 19'h00010, 24'h000065, 8'd1, 1'b0, 3'b101, 1'b0);
        wr_idx(6, 19'h00020, 24'hABCDEF, 8'd9, 1'b1, 3'b011, 1'b0);
        wr_idx(7, 19'h00021, 24'h123456, 8'd1, 1'b0, 3'b011, 1'b1);

        // R2 R3 R4 R5 R11: vector walk
        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].va, VECS[i].asid, VECS[i].acc);
            check(rs_valid && ({rs_hit, rs_miss, rs_fault} == st_bits(VECS[i].st)) && !rs_multi,
                  $sformatf("R2/R3/R5/R11 vector %0d status", i),
                  {60'd0, rs_valid, rs_hit, rs_miss, rs_fault}, {60'd1, st_bits(VECS[i].st)});
            check(rs_pa == VECS[i].pa, $sformatf("R4 vector %0d address", i),
                  {28'd0, rs_pa}, {28'd0, VECS[i].pa});
        end

        // R9: indexed read of slot 3
        mg_index = 5'd3;
        mgmt(OP_READ);
        check({rd_vpn, rd_pfn, rd_asid, rd_global, rd_prot, rd_dirty, rd_valid} ==
              {19'h0000A, 24'h0000AA, 8'd2, 1'b0, 3'b111, 1'b1, 1'b1}, "R9 read-back of slot 3",
              {7'd0, rd_vpn, rd_pfn, rd_asid, rd_global, rd_prot, rd_dirty, rd_valid},
              {7'd0, 19'h0000A, 24'h0000AA, 8'd2, 1'b0, 3'b111, 1'b1, 1'b1});

        // R8: probes
        probe(19'h0000A, 8'd2);
        check(!mg_nf && mg_slot == 5'd3, "R8 probe finds slot 3", {58'd0, mg_nf, mg_slot}, 64'd3);
        probe(19'h00099, 8'd1);
        check(mg_nf, "R8 probe not found", {63'd0, mg_nf}, 64'd1);
        probe(19'h00020, 8'd55);
        check(!mg_nf && mg_slot == 5'd6, "R8 probe global slot 6", {58'd0, mg_nf, mg_slot}, 64'd6);

        // R10: duplicate match, lowest index wins
        wr_idx(9, 19'h0000A, 24'h000777, 8'd1, 1'b0, 3'b111, 1'b1);
        lookup(32'h0000A010, 8'd1, A_RD);
        check(rs_hit && rs_multi && rs_pa == 36'h000064010, "R10 lowest index wins with multi flag",
              {27'd0, rs_multi, rs_pa}, {27'd1, 36'h000064010});
        probe(19'h0000A, 8'd1);
        check(!mg_nf && mg_multi && mg_slot == 5'd2, "R10 probe multi lowest slot",
              {57'd0, mg_nf, mg_multi, mg_slot}, {57'd0, 1'b0, 1'b1, 5'd2});

        // R9: write and lookup in the same cycle see old contents
        @(negedge clk);
        set_fields(19'h00040, 24'h004040, 8'd1, 1'b0, 3'b111, 1'b1);
        mg_index = 5'd12; mg_op = OP_WIDX;
        lk_valid = 1'b1; lk_va = 32'h00040000; lk_asid = 8'd1; lk_acc = A_RD;
        @(negedge clk);
        mg_op = OP_IDLE; lk_valid = 1'b0;
        check(rs_miss, "R9 same-cycle lookup sees old slot", {61'd0, rs_hit, rs_miss, rs_fault}, 64'b010);
        lookup(32'h00040000, 8'd1, A_RD);
        check(rs_hit && rs_pa == 36'h004040000, "R9 written slot then hits",
              {27'd0, rs_hit, rs_pa}, {27'd1, 36'h004040000});

        // R7: pinned count and random writes
        mg_wired = 6'd8;
        mgmt(OP_WIRED);
        check(mg_ack, "R12 set pinned ack", {63'd0, mg_ack}, 64'd1);
        for (int i = 0; i < 20; i++) begin
            set_fields(19'(32'h100 + i), 24'(32'h500 + i), 8'd1, 1'b0, 3'b111, 1'b1);
            mgmt(OP_WRND);
            check(mg_ack && mg_slot >= 5'd8, $sformatf("R7 random write %0d above pinned", i),
                  {59'd0, mg_slot}, 64'd8);
        end
        lookup(32'h00113000, 8'd1, A_RD);
        check(rs_hit && rs_pa == 36'h000513000, "R7 last random write resident",
              {27'd0, rs_hit, rs_pa}, {27'd1, 36'h000513000});
        lookup(32'h0000A123, 8'd2, A_RD);
        check(rs_hit && rs_pa == 36'h0000AA123, "R7 pinned slot 3 survives",
              {27'd0, rs_hit, rs_pa}, {27'd1, 36'h0000AA123});
        mg_wired = 6'd40;
        mgmt(OP_WIRED);
        for (int i = 0; i < 3; i++) begin
            set_fields(19'(32'h200 + i), 24'h000600, 8'd1, 1'b0, 3'b111, 1'b1);
            mgmt(OP_WRND);
            check(mg_slot == 5'd31, "R7 oversized pinned count clamps to last slot",
                  {59'd0, mg_slot}, 64'd31);
        end

        // R6: flush
        mgmt(OP_FLUSH);
        lookup(32'h0000A123, 8'd1, A_RD);
        check(rs_miss, "R6 lookup misses after flush", {61'd0, rs_hit, rs_miss, rs_fault}, 64'b010);
        probe(19'h00020, 8'd9);
        check(mg_nf, "R6 global slot gone after flush", {63'd0, mg_nf}, 64'd1);
        mg_index = 5'd6;
        mgmt(OP_READ);
        check(!rd_valid, "R6 read-back valid cleared", {63'd0, rd_valid}, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule